// File: doc/BRIEF.md
# Sample-Queued Pulse-Width Modulator

A single-channel pulse-width modulator programmed through a small word-addressed register port. Software writes a control word (enable, clock divide ratio, counter clock source and three stored run-in-mode flags), a period value and a stream of duty samples. Samples are queued in a four-entry first-in first-out buffer. The counter takes exactly one sample at the start of every output period, so software can pre-load a short sequence of duty values that the output then steps through, one per period.

The output is high from the start of each period until the counter reaches the current sample. A period lasts the programmed period value plus two counter steps, and every counter step lasts the divide ratio in clock cycles. A self-clearing software reset returns every register to zero and empties the queue. While it runs, the reset bit reads back as 1 and bus writes are ignored.

Control is a three-state machine. IDLE (counter parked, output low) moves to RUN when the enable bit is set. RUN moves back to IDLE when enable is cleared. Either state moves to SWRST when a control write sets the reset bit. SWRST returns to IDLE after a fixed number of clock cycles. The move from IDLE to RUN starts a fresh period, and so does every wrap of the counter while in RUN.

Top module: `pwm_fifo_gen`

## Requirements
- R1: After the asynchronous reset, reads of control (0x00), status (0x04), sample (0x0C) and period (0x10) all return 0, and the output is low.
- R2: Control fields read back as written: bit 0 enable, bits [15:4] divide ratio minus 1, bits [17:16] clock source, bits 22/23/24 stored mode flags. The period register holds its 16-bit value. A read of an unmapped offset returns 0.
- R3: Each write to offset 0x0C queues one sample. Status bits [2:0] give the number of queued samples (0 to 4).
- R4: A sample write to a full queue that is not popped in the same cycle is dropped and sets status bit 4. That flag stays set until a software reset.
- R5: With clock source 1, a period lasts (period + 2) × (divide field + 1) clock cycles.
- R6: The output is high for the first S counter steps of a period, where S is the current sample. S = 0 gives a constant low output. S ≥ period + 2 gives a constant high output.
- R7: Each period start pops one sample, in write order. If the queue is empty, the previous sample is reused. A read of offset 0x0C returns the sample in use.
- R8: When a sample write and a period-start pop fall in the same cycle, both take effect. This applies even when the queue is full, and the overflow flag is not set in that case.
- R9: A control write with bit 3 set clears all registers, the queue and the overflow flag, and parks the output low. Control then reads 0x00000008 for 4 cycles and 0 afterwards. Bus writes made during those cycles are ignored.
- R10: Clearing enable drives the output low from the next cycle and freezes the queue. Setting it again starts a new period with the retained sample.
- R11: Clock source 1 advances the divider every cycle. Source 2 advances it only in cycles where ref_en is high. Sources 0 and 3 stop it, so the output and the queue hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and counter clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_en | input | 1 | Qualifier for the alternate counter clock source |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 5 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the addressed register, combinational |
| pwm_out | output | 1 | Modulated output |

## Verification
The collision that matters is a sample write landing in the same cycle as the period-start pop, most sharply when the queue is full. The bench fills the queue and enables the counter with a known period, so that the pop edges fall at fixed cycle offsets. It then sweeps a second write across the offsets on both sides of the first period wrap. Status is read at a fixed later cycle, and the expected level and overflow flag are worked out for each offset: writes before the wrap overflow, the write on the wrap is accepted, and writes after the wrap fit. Output waveforms are compared cycle by cycle against a period/sample model, for directed and seeded random settings.

// File: rtl/pwm_fifo_pkg.sv
package pwm_fifo_pkg;

    localparam logic [4:0] OFS_CTRL = 5'h00;
    localparam logic [4:0] OFS_STAT = 5'h04;
    localparam logic [4:0] OFS_SAMP = 5'h0C;
    localparam logic [4:0] OFS_PER  = 5'h10;

    localparam int CB_EN    = 0;
    localparam int CB_SWR   = 3;
    localparam int CB_PS_LO = 4;
    localparam int PRESC_W  = 12;
    localparam int CB_SRC   = 16;
    localparam int CB_DBG   = 22;
    localparam int CB_WAIT  = 23;
    localparam int CB_DOZE  = 24;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_RUN   = 2'd1,
        ST_SWRST = 2'd2
    } pwm_state_e;

    typedef struct packed {
        logic               doze;
        logic               wait_run;
        logic               dbg;
        logic [1:0]         src;
        logic [PRESC_W-1:0] presc;
        logic               en;
    } ctrl_t;

endpackage

// File: rtl/pwm_sample_fifo.sv
module pwm_sample_fifo #(
    parameter int DEPTH = 4,
    parameter int WIDTH = 16,
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             push,
    input  logic             pop,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout,
    output logic [CW-1:0]    level,
    output logic             empty,
    output logic             drop
);
    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW-1:0]    rd_ptr, wr_ptr;
    logic             full, do_push, do_pop;

    function automatic logic [AW-1:0] step_ptr(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        full    = (level == CW'(DEPTH));
        empty   = (level == '0);
        do_pop  = pop && !empty;
        do_push = push && (!full || do_pop);
        drop    = push && !do_push;
        dout    = mem[rd_ptr];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
            level  <= '0;
        end else if (flush) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
            level  <= '0;
        end else begin
            if (do_push) wr_ptr <= step_ptr(wr_ptr);
            if (do_pop)  rd_ptr <= step_ptr(rd_ptr);
            if (do_push && !do_pop)      level <= level + 1'b1;
            else if (do_pop && !do_push) level <= level - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (do_push && !flush) mem[wr_ptr] <= din;
    end
endmodule

// File: rtl/pwm_prescaler.sv
module pwm_prescaler #(
    parameter int DIV_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             step,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    logic [DIV_W-1:0] pcnt;

    assign tick = run && step && (pcnt >= div);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      pcnt <= '0;
        else if (!run)   pcnt <= '0;
        else if (step)   pcnt <= (pcnt >= div) ? '0 : pcnt + 1'b1;
    end
endmodule

// File: rtl/pwm_period_ctr.sv
module pwm_period_ctr #(
    parameter int PER_W = 16,
    parameter int SMP_W = 16,
    localparam int CNT_W = PER_W + 1,
    localparam int CMP_W = (CNT_W > SMP_W) ? CNT_W : SMP_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             begin_run,
    input  logic             running,
    input  logic             tick,
    input  logic [PER_W-1:0] period,
    input  logic             fifo_empty,
    input  logic [SMP_W-1:0] fifo_dout,
    output logic             pop_req,
    output logic [SMP_W-1:0] cur_smp,
    output logic             pwm_out
);
    logic [CNT_W-1:0] cnt, last;
    logic             wrap;

    always_comb begin
        last    = {1'b0, period} + CNT_W'(1);
        wrap    = running && tick && (cnt >= last);
        pop_req = begin_run || wrap;
        pwm_out = running && (CMP_W'(cnt) < CMP_W'(cur_smp));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt     <= '0;
            cur_smp <= '0;
        end else if (clear) begin
            cnt     <= '0;
            cur_smp <= '0;
        end else if (pop_req) begin
            cnt <= '0;
            if (!fifo_empty) cur_smp <= fifo_dout;
        end else if (running && tick) begin
            cnt <= cnt + 1'b1;
        end else if (!running) begin
            cnt <= '0;
        end
    end
endmodule

// File: rtl/pwm_fifo_gen.sv
module pwm_fifo_gen
    import pwm_fifo_pkg::*;
#(
    parameter int DEPTH      = 4,
    parameter int SMP_W      = 16,
    parameter int PER_W      = 16,
    parameter int RST_CYCLES = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        ref_en,
    input  logic        bus_sel,
    input  logic        bus_wr,
    input  logic [4:0]  bus_addr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    output logic        pwm_out
);
    localparam int CW  = $clog2(DEPTH + 1);
    localparam int RCW = (RST_CYCLES > 2) ? $clog2(RST_CYCLES) : 1;

    pwm_state_e       state, state_nx;
    ctrl_t            ctrl_q;
    logic [PER_W-1:0] period_q;
    logic             ovf_q;
    logic [RCW-1:0]   rst_cnt;

    logic             wr_ok, ctrl_wr, swr_req, smp_wr, per_wr;
    logic             fifo_pop, fifo_empty, fifo_drop;
    logic [SMP_W-1:0] fifo_dout, cur_smp;
    logic [CW-1:0]    fifo_cnt;
    logic             running, begin_run, src_step, tick;
    logic             unused_bits;

    // Bus write decode
    always_comb begin
        wr_ok   = bus_sel && bus_wr && (state != ST_SWRST);
        ctrl_wr = wr_ok && (bus_addr == OFS_CTRL);
        swr_req = ctrl_wr && bus_wdata[CB_SWR];
        smp_wr  = wr_ok && (bus_addr == OFS_SAMP);
        per_wr  = wr_ok && (bus_addr == OFS_PER);
    end

    // Next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: begin
                if (swr_req)         state_nx = ST_SWRST;
                else if (ctrl_q.en)  state_nx = ST_RUN;
            end
            ST_RUN: begin
                if (swr_req)         state_nx = ST_SWRST;
                else if (!ctrl_q.en) state_nx = ST_IDLE;
            end
            ST_SWRST: begin
                if (rst_cnt == RCW'(RST_CYCLES - 1)) state_nx = ST_IDLE;
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                  rst_cnt <= '0;
        else if (state == ST_SWRST)  rst_cnt <= rst_cnt + 1'b1;
        else                         rst_cnt <= '0;
    end

    // Programmable registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q   <= '0;
            period_q <= '0;
            ovf_q    <= 1'b0;
        end else if (swr_req) begin
            ctrl_q   <= '0;
            period_q <= '0;
            ovf_q    <= 1'b0;
        end else begin
            if (ctrl_wr) begin
                ctrl_q <= '{en:       bus_wdata[CB_EN],
                            presc:    bus_wdata[CB_PS_LO +: PRESC_W],
                            src:      bus_wdata[CB_SRC +: 2],
                            dbg:      bus_wdata[CB_DBG],
                            wait_run: bus_wdata[CB_WAIT],
                            doze:     bus_wdata[CB_DOZE]};
            end
            if (per_wr)    period_q <= bus_wdata[PER_W-1:0];
            if (fifo_drop) ovf_q    <= 1'b1;
        end
    end

    // Outputs of the state machine
    always_comb begin
        running   = (state == ST_RUN);
        begin_run = (state == ST_IDLE) && ctrl_q.en && !swr_req;
        unique case (ctrl_q.src)
            2'd1:    src_step = 1'b1;
            2'd2:    src_step = ref_en;
            default: src_step = 1'b0;
        endcase
    end

    // Register read mux
    always_comb begin
        unique case (bus_addr)
            OFS_CTRL: bus_rdata = {7'd0, ctrl_q.doze, ctrl_q.wait_run, ctrl_q.dbg, 4'd0,
                                   ctrl_q.src, ctrl_q.presc, (state == ST_SWRST), 2'd0, ctrl_q.en};
            OFS_STAT: bus_rdata = {27'd0, ovf_q, 1'b0, 3'(fifo_cnt)};
            OFS_SAMP: bus_rdata = 32'(cur_smp);
            OFS_PER:  bus_rdata = 32'(period_q);
            default:  bus_rdata = '0;
        endcase
    end

    assign unused_bits = ^{bus_wdata[31:25], bus_wdata[21:18], bus_wdata[2:1]};

    pwm_sample_fifo #(.DEPTH(DEPTH), .WIDTH(SMP_W)) u_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .flush (swr_req),
        .push  (smp_wr),
        .pop   (fifo_pop),
        .din   (bus_wdata[SMP_W-1:0]),
        .dout  (fifo_dout),
        .level (fifo_cnt),
        .empty (fifo_empty),
        .drop  (fifo_drop)
    );

    pwm_prescaler #(.DIV_W(PRESC_W)) u_presc (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (running),
        .step  (src_step),
        .div   (ctrl_q.presc),
        .tick  (tick)
    );

    pwm_period_ctr #(.PER_W(PER_W), .SMP_W(SMP_W)) u_ctr (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear      (swr_req),
        .begin_run  (begin_run),
        .running    (running),
        .tick       (tick),
        .period     (period_q),
        .fifo_empty (fifo_empty),
        .fifo_dout  (fifo_dout),
        .pop_req    (fifo_pop),
        .cur_smp    (cur_smp),
        .pwm_out    (pwm_out)
    );
endmodule

// File: rtl/pwm_fifo_gen_chk.sv
module pwm_fifo_gen_chk
    import pwm_fifo_pkg::*;
#(
    parameter int DEPTH      = 4,
    parameter int RST_CYCLES = 4,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input pwm_state_e    state,
    input logic          pwm_out,
    input logic [CW-1:0] level,
    input logic          ovf,
    input logic          swr_req,
    input logic          push,
    input logic          pop
);
    logic [7:0] swr_len;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                 swr_len <= '0;
        else if (state == ST_SWRST) swr_len <= swr_len + 1'b1;
        else                        swr_len <= '0;
    end

    assert_level_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
        int'(level) <= DEPTH);

    assert_level_push_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !pop && !swr_req && int'(level) < DEPTH) |=> int'(level) == int'($past(level)) + 1);

    assert_level_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !swr_req |=> (int'(level) <= int'($past(level)) + 1) && (int'(level) + 1 >= int'($past(level))));

    assert_ovf_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf && !swr_req) |=> ovf);

    assert_swr_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
        swr_req |=> (state == ST_SWRST) && (level == '0) && !ovf && !pwm_out);

    assert_swr_bounded_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SWRST) |-> int'(swr_len) < RST_CYCLES);

    assert_parked_low_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_RUN) |-> !pwm_out);
endmodule

bind pwm_fifo_gen pwm_fifo_gen_chk #(.DEPTH(DEPTH), .RST_CYCLES(RST_CYCLES)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .state   (state),
    .pwm_out (pwm_out),
    .level   (fifo_cnt),
    .ovf     (ovf_q),
    .swr_req (swr_req),
    .push    (smp_wr),
    .pop     (fifo_pop)
);

// File: tb/pwm_fifo_gen_test.sv
module pwm_fifo_gen_test;
    localparam logic [4:0] A_CTRL = 5'h00;
    localparam logic [4:0] A_STAT = 5'h04;
    localparam logic [4:0] A_HOLE = 5'h08;
    localparam logic [4:0] A_SMP  = 5'h0C;
    localparam logic [4:0] A_PER  = 5'h10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ref_en = 1'b1;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        pwm_out;

    int n_chk = 0;
    int n_err = 0;
    int smp [4];
    int last0 = 0;
    logic [31:0] rd;

    always #2 clk = ~clk;

    pwm_fifo_gen uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .ref_en    (ref_en),
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .pwm_out   (pwm_out)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rdreg(input logic [4:0] a, output logic [31:0] d);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        bus_sel = 1'b0;
        @(negedge clk);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic logic exp_out(input int t, input int per, input int ratio, input int n);
        int len = ratio * (per + 2);
        int k   = t / len;
        int pos = (t % len) / ratio;
        int s   = (n == 0) ? last0 : smp[(k < n) ? k : n - 1];
        return pos < s;
    endfunction

    task automatic soft_reset();
        wr(A_CTRL, 32'h8);
        idle(4);
        last0 = 0;
    endtask

    function automatic logic [31:0] ctrl_word(input int src, input int ratio, input bit en);
        return (32'(src) << 16) | (32'(ratio - 1) << 4) | 32'(en);
    endfunction

    task automatic trace_only(input string tag, input int per, input int ratio, input int n);
        int mism = 0;
        int len  = ratio * (per + 2) * (n + 2);
        for (int t = 0; t < len; t++) begin
            @(negedge clk);
            if (pwm_out !== exp_out(t, per, ratio, n)) mism++;
        end
        check(tag, 32'(mism), 32'd0);
    endtask

    task automatic run_trace(input string tag, input int per, input int ratio, input int n, input int src);
        soft_reset();
        wr(A_PER, 32'(per));
        wr(A_CTRL, ctrl_word(src, ratio, 1'b0));
        for (int i = 0; i < n; i++) wr(A_SMP, 32'(smp[i]));
        wr(A_CTRL, ctrl_word(src, ratio, 1'b1));
        trace_only(tag, per, ratio, n);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        int o0, ok;
        logic [31:0] s0;
        void'($urandom(32'd5150));
        idle(3);
        rst_n = 1'b1;
        idle(1);

        // R1 reset values
        rdreg(A_CTRL, rd); check("R1 ctrl", rd, 32'h0);
        rdreg(A_STAT, rd); check("R1 status", rd, 32'h0);
        rdreg(A_SMP,  rd); check("R1 sample", rd, 32'h0);
        rdreg(A_PER,  rd); check("R1 period", rd, 32'h0);
        check("R1 output", 32'(pwm_out), 32'h0);

        // R2 field readback
        wr(A_CTRL, 32'h01C2_ABC0);
        rdreg(A_CTRL, rd); check("R2 ctrl fields", rd, 32'h01C2_ABC0);
        wr(A_PER, 32'h0000_1234);
        rdreg(A_PER, rd);  check("R2 period", rd, 32'h0000_1234);
        rdreg(A_HOLE, rd); check("R2 unmapped", rd, 32'h0);

        // R3 / R4 queue level and overflow
        for (int i = 0; i < 3; i++) wr(A_SMP, 32'(i + 1));
        rdreg(A_STAT, rd); check("R3 level three", rd, 32'h3);
        wr(A_SMP, 32'h9);
        wr(A_SMP, 32'hA);
        rdreg(A_STAT, rd); check("R4 full plus overflow", rd, 32'h14);

        // R9 software reset
        wr(A_CTRL, 32'h8);
        rdreg(A_CTRL, rd); check("R9 busy first", rd, 32'h8);
        wr(A_PER, 32'h55);
        rdreg(A_CTRL, rd); check("R9 busy third", rd, 32'h8);
        idle(1);
        rdreg(A_CTRL, rd); check("R9 done", rd, 32'h0);
        rdreg(A_PER,  rd); check("R9 write ignored", rd, 32'h0);
        rdreg(A_STAT, rd); check("R9 queue and flag cleared", rd, 32'h0);
        check("R9 output low", 32'(pwm_out), 32'h0);

        // R7 ordering, R6 shape, R5 length
        smp = '{1, 2, 3, 4};
        run_trace("R7 order of samples", 6, 1, 4, 1);
        rdreg(A_SMP, rd);  check("R7 last sample reused", rd, 32'h4);
        rdreg(A_STAT, rd); check("R3 drained", rd, 32'h0);
        smp = '{0, 0, 0, 0};
        run_trace("R6 zero sample low", 4, 2, 1, 1);
        smp = '{6, 0, 0, 0};
        run_trace("R6 full sample high", 4, 3, 1, 1);
        smp = '{3, 5, 0, 0};
        run_trace("R5 prescaled period", 5, 4, 2, 1);

        // R11 alternate source
        smp = '{2, 0, 0, 0};
        run_trace("R11 alternate source", 3, 1, 1, 2);
        ref_en = 1'b0;
        idle(1);
        o0 = int'(pwm_out);
        rdreg(A_STAT, s0);
        ok = 1;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (int'(pwm_out) != o0) ok = 0;
        end
        check("R11 stopped source holds output", 32'(ok), 32'd1);
        rdreg(A_STAT, rd); check("R11 stopped source holds queue", rd, s0);
        ref_en = 1'b1;

        // R10 disable and re-enable
        smp = '{3, 0, 0, 0};
        run_trace("R10 before disable", 6, 1, 1, 1);
        wr(A_CTRL, ctrl_word(1, 1, 1'b0));
        idle(1);
        ok = 1;
        for (int i = 0; i < 10; i++) begin
            if (pwm_out !== 1'b0) ok = 0;
            @(negedge clk);
        end
        check("R10 low while disabled", 32'(ok), 32'd1);
        last0 = 3;
        wr(A_CTRL, ctrl_word(1, 1, 1'b1));
        trace_only("R10 restart with retained sample", 6, 1, 0);

        // R8 write and pop in the same cycle, swept across the wrap
        for (int d = 5; d <= 12; d++) begin
            soft_reset();
            wr(A_PER, 32'd6);
            wr(A_CTRL, ctrl_word(1, 1, 1'b0));
            for (int i = 0; i < 4; i++) wr(A_SMP, 32'd2);
            wr(A_CTRL, ctrl_word(1, 1, 1'b1));
            idle(1);
            wr(A_SMP, 32'd3);
            idle(d - 3);
            wr(A_SMP, 32'd5);
            idle(15 - d);
            rdreg(A_STAT, rd);
            check($sformatf("R8 write at offset %0d", d), rd, (d < 9) ? 32'h13 : 32'h04);
        end

        // R6 seeded random settings
        for (int it = 0; it < 6; it++) begin
            int per   = $urandom_range(0, 9);
            int ratio = $urandom_range(1, 3);
            int n     = $urandom_range(0, 4);
            for (int i = 0; i < 4; i++) smp[i] = $urandom_range(0, per + 3);
            run_trace($sformatf("R6 random set %0d", it), per, ratio, n, 1);
        end

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule